// File: doc/BRIEF.md
# Serial Power-Mode Decoder for a Dual-Channel SAR Converter

This block sits on the converter side of a serial sampling interface. It watches the active-low chip-select and the serial clock and decides which power state the converter is in: normal, partial power-down or full power-down. Both pins are resynchronised to the system clock. The block counts serial-clock falling edges in every chip-select-low frame. When chip-select rises it sorts the frame into one of three kinds. A complete frame reaches the programmable full edge count. An aborted frame has at least the minimum edge count but fewer than the full count. A frame with fewer edges than the minimum is ignored.

A complete frame always restores normal operation. Each aborted frame moves the converter one step deeper: from normal to partial power-down, and from partial to full power-down. The depth reached is therefore set purely by where chip-select rises. When a frame starts while the converter is powered down, a wake-up delay counter is loaded. The delay is counted in system clock cycles, and its length depends on which power-down mode is being left. The ready flag stays low until that count has expired and the converter is back in normal mode.

A track/hold control is held while the converter is powered down. During a wake-up from partial power-down, it returns to track on the first serial-clock edge of the wake-up frame. A synchronous reset loads an arbitrary start mode, which stands in for the undefined state after power is applied.

Top module: `pmd_power_decoder`

## Requirements
- R1: While `rst_i` is high, the mode is loaded from `rst_mode_i` on each clock. After reset, `ready_o` is 1 and `track_o` is 1 exactly when that mode is normal. The mode encoding on `rst_mode_i` and `mode_o` is 2'b00 normal, 2'b01 partial power-down and 2'b10 full power-down; 2'b11 loads full power-down.
- R2: A frame whose chip-select rises after at least COMPLETE_EDGES (default 10) serial-clock falling edges puts the mode into normal, whatever the mode was before.
- R3: A frame whose chip-select rises after at least ABORT_MIN_EDGES (default 2) but fewer than COMPLETE_EDGES falling edges moves the mode from normal to partial power-down.
- R4: Such an aborted frame moves the mode from partial power-down to full power-down, and leaves it at full power-down when already there.
- R5: A frame with fewer than ABORT_MIN_EDGES falling edges leaves `mode_o` unchanged.
- R6: A frame that starts in partial power-down loads a delay of PARTIAL_WAKE_CYC cycles, counted from the chip-select falling edge. `ready_o` stays low until the delay has expired, and then rises once the mode is normal.
- R7: A frame that starts in full power-down loads a delay of FULL_WAKE_CYC cycles, with the same rule for `ready_o`.
- R8: `ready_o` is 0 in either power-down mode. In normal mode with no delay pending it is 1, and it stays 1 through normal-mode frames.
- R9: `track_o` (1 = track, 0 = hold) is 0 in power-down outside a partial wake-up. During a wake-up frame from partial power-down, it goes to 1 on the first serial-clock edge after chip-select falls. In a wake-up from full power-down it stays 0 until a complete frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rst_mode_i | input | 2 | Mode loaded during reset |
| cs_n_i | input | 1 | Serial chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| mode_o | output | 2 | Current power mode |
| ready_o | output | 1 | A conversion result would be valid |
| track_o | output | 1 | Track/hold control, 1 = track |

## Verification
The bench builds the block with PARTIAL_WAKE_CYC at 64 and FULL_WAKE_CYC at 1500, and leaves the edge thresholds and the two-stage synchroniser at their defaults. With these delays, both wake-up windows fit in a short run. A complete wake-up frame clocked fast finishes well before either delay expires, so the ready flag can be seen low just before its deadline and high just after. The default thresholds let the bench step through frames of 0, 1, 2, 5, 9, 10 and 12 falling edges, which covers both sides of each boundary.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL  = 2'b00,
      PM_PARTIAL = 2'b01,
      PM_FULL    = 2'b10
   } pm_mode_t;

   typedef enum logic [1:0] {
      FC_IGNORED  = 2'b00,
      FC_ABORTED  = 2'b01,
      FC_COMPLETE = 2'b10
   } frame_cls_t;

   function automatic pm_mode_t pm_decode(input logic [1:0] raw);
      case (raw)
         2'b00:   return PM_NORMAL;
         2'b01:   return PM_PARTIAL;
         default: return PM_FULL;
      endcase
   endfunction

endpackage

// File: rtl/pmd_pin_sampler.sv
module pmd_pin_sampler #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic level;
   logic prev_q;

   if (STAGES < 0) begin : g_bad_stages
      $error("pmd_pin_sampler: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign level = pin_i;
   end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            sync_q <= {STAGES{IDLE}};
         end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
               sync_q[i] <= sync_q[i-1];
            end
            sync_q[0] <= pin_i;
         end
      end
      assign level = sync_q[STAGES-1];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= IDLE;
      else       prev_q <= level;
   end

   assign level_o = level;
   assign rise_o  = level & ~prev_q;
   assign fall_o  = ~level & prev_q;

endmodule

// File: rtl/pmd_frame_counter.sv
module pmd_frame_counter
   import pmd_pkg::*;
#(
   parameter int COMPLETE_EDGES  = 10,
   parameter int ABORT_MIN_EDGES = 2,
   parameter int CNT_W           = $clog2(COMPLETE_EDGES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             cs_fall_i,
   input  logic             cs_low_i,
   input  logic             sclk_fall_i,
   output logic [CNT_W-1:0] count_o,
   output frame_cls_t       cls_o
);

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] FULL_THR = CNT_W'(COMPLETE_EDGES);
   localparam logic [CNT_W-1:0] MIN_THR  = CNT_W'(ABORT_MIN_EDGES);

   if (ABORT_MIN_EDGES < 1 || ABORT_MIN_EDGES >= COMPLETE_EDGES) begin : g_bad_thr
      $error("pmd_frame_counter: need 1 <= ABORT_MIN_EDGES < COMPLETE_EDGES");
   end
   if ((1 << CNT_W) <= COMPLETE_EDGES) begin : g_bad_width
      $error("pmd_frame_counter: CNT_W too narrow for COMPLETE_EDGES");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (cs_fall_i) begin
         cnt_q <= '0;
      end else if (cs_low_i && sclk_fall_i && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      if (cnt_q >= FULL_THR)     cls_o = FC_COMPLETE;
      else if (cnt_q >= MIN_THR) cls_o = FC_ABORTED;
      else                       cls_o = FC_IGNORED;
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/pmd_mode_fsm.sv
module pmd_mode_fsm
   import pmd_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [1:0] rst_mode_i,
   input  logic       cs_fall_i,
   input  logic       cs_rise_i,
   input  logic       cs_low_i,
   input  logic       sclk_edge_i,
   input  frame_cls_t cls_i,
   output pm_mode_t   mode_o,
   output logic       track_o,
   output logic       wake_start_o,
   output logic       wake_full_o,
   output logic       wake_cancel_o
);

   pm_mode_t mode_q;
   logic     track_q;
   logic     pwake_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mode_q  <= pm_decode(rst_mode_i);
         track_q <= (pm_decode(rst_mode_i) == PM_NORMAL);
         pwake_q <= 1'b0;
      end else if (cs_rise_i) begin
         pwake_q <= 1'b0;
         case (cls_i)
            FC_COMPLETE: begin
               mode_q  <= PM_NORMAL;
               track_q <= 1'b1;
            end
            FC_ABORTED: begin
               mode_q  <= (mode_q == PM_NORMAL) ? PM_PARTIAL : PM_FULL;
               track_q <= 1'b0;
            end
            default: begin
               track_q <= (mode_q == PM_NORMAL);
            end
         endcase
      end else begin
         if (cs_fall_i) begin
            pwake_q <= (mode_q == PM_PARTIAL);
         end else if (pwake_q && cs_low_i && sclk_edge_i) begin
            track_q <= 1'b1;
         end
      end
   end

   assign mode_o        = mode_q;
   assign track_o       = track_q;
   assign wake_start_o  = cs_fall_i && (mode_q != PM_NORMAL);
   assign wake_full_o   = (mode_q == PM_FULL);
   assign wake_cancel_o = cs_rise_i && (cls_i == FC_ABORTED);

endmodule

// File: rtl/pmd_wake_timer.sv
module pmd_wake_timer #(
   parameter int PARTIAL_WAKE_CYC = 42,
   parameter int FULL_WAKE_CYC    = 750000,
   parameter int TMR_W            = $clog2(FULL_WAKE_CYC + 1)
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_i,
   input  logic full_i,
   input  logic cancel_i,
   output logic busy_o
);

   localparam logic [TMR_W-1:0] LOAD_PART = TMR_W'(PARTIAL_WAKE_CYC);
   localparam logic [TMR_W-1:0] LOAD_FULL = TMR_W'(FULL_WAKE_CYC);

   if (PARTIAL_WAKE_CYC < 1 || FULL_WAKE_CYC < PARTIAL_WAKE_CYC) begin : g_bad_delay
      $error("pmd_wake_timer: need 1 <= PARTIAL_WAKE_CYC <= FULL_WAKE_CYC");
   end

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (cancel_i) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= full_i ? LOAD_FULL : LOAD_PART;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/pmd_power_decoder.sv
module pmd_power_decoder
   import pmd_pkg::*;
#(
   parameter int SYNC_STAGES      = 2,
   parameter int COMPLETE_EDGES   = 10,
   parameter int ABORT_MIN_EDGES  = 2,
   parameter int PARTIAL_WAKE_CYC = 42,
   parameter int FULL_WAKE_CYC    = 750000
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [1:0] rst_mode_i,
   input  logic       cs_n_i,
   input  logic       sclk_i,
   output logic [1:0] mode_o,
   output logic       ready_o,
   output logic       track_o
);

   localparam int CNT_W = $clog2(COMPLETE_EDGES + 1);
   localparam int TMR_W = $clog2(FULL_WAKE_CYC + 1);

   logic             cs_level, cs_rise, cs_fall;
   logic             sk_level, sk_rise, sk_fall;
   logic [CNT_W-1:0] edge_count;
   frame_cls_t       frame_cls;
   pm_mode_t         mode;
   logic             wake_start, wake_full, wake_cancel, wake_busy;

   pmd_pin_sampler #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs (
      .clk_i(clk_i), .rst_i(rst_i), .pin_i(cs_n_i),
      .level_o(cs_level), .rise_o(cs_rise), .fall_o(cs_fall)
   );

   pmd_pin_sampler #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sclk (
      .clk_i(clk_i), .rst_i(rst_i), .pin_i(sclk_i),
      .level_o(sk_level), .rise_o(sk_rise), .fall_o(sk_fall)
   );

   pmd_frame_counter #(
      .COMPLETE_EDGES(COMPLETE_EDGES), .ABORT_MIN_EDGES(ABORT_MIN_EDGES), .CNT_W(CNT_W)
   ) u_frame (
      .clk_i(clk_i), .rst_i(rst_i), .cs_fall_i(cs_fall), .cs_low_i(~cs_level),
      .sclk_fall_i(sk_fall), .count_o(edge_count), .cls_o(frame_cls)
   );

   pmd_mode_fsm u_fsm (
      .clk_i(clk_i), .rst_i(rst_i), .rst_mode_i(rst_mode_i),
      .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .cs_low_i(~cs_level),
      .sclk_edge_i(sk_rise | sk_fall), .cls_i(frame_cls),
      .mode_o(mode), .track_o(track_o), .wake_start_o(wake_start),
      .wake_full_o(wake_full), .wake_cancel_o(wake_cancel)
   );

   pmd_wake_timer #(
      .PARTIAL_WAKE_CYC(PARTIAL_WAKE_CYC), .FULL_WAKE_CYC(FULL_WAKE_CYC), .TMR_W(TMR_W)
   ) u_timer (
      .clk_i(clk_i), .rst_i(rst_i), .start_i(wake_start), .full_i(wake_full),
      .cancel_i(wake_cancel), .busy_o(wake_busy)
   );

   logic unused_level;
   assign unused_level = sk_level;

   assign mode_o  = mode;
   assign ready_o = (mode == PM_NORMAL) && !wake_busy;

endmodule

// File: rtl/pmd_power_decoder_chk.sv
module pmd_power_decoder_chk #(
   parameter int COMPLETE_EDGES  = 10,
   parameter int ABORT_MIN_EDGES = 2,
   parameter int CNT_W           = 4
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic [1:0]       mode_o,
   input logic             ready_o,
   input logic             track_o,
   input logic             cs_rise,
   input logic [CNT_W-1:0] edge_count
);

   localparam logic [CNT_W-1:0] FULL_THR = CNT_W'(COMPLETE_EDGES);
   localparam logic [CNT_W-1:0] MIN_THR  = CNT_W'(ABORT_MIN_EDGES);

   a_r2_complete_to_normal: assert property (@(posedge clk_i) disable iff (rst_i)
      cs_rise && edge_count >= FULL_THR |=> mode_o == 2'b00);

   a_r3_abort_from_normal: assert property (@(posedge clk_i) disable iff (rst_i)
      cs_rise && edge_count >= MIN_THR && edge_count < FULL_THR && mode_o == 2'b00
      |=> mode_o == 2'b01);

   a_r4_abort_deepens: assert property (@(posedge clk_i) disable iff (rst_i)
      cs_rise && edge_count >= MIN_THR && edge_count < FULL_THR && mode_o != 2'b00
      |=> mode_o == 2'b10);

   a_r5_mode_held: assert property (@(posedge clk_i) disable iff (rst_i)
      !(cs_rise && edge_count >= MIN_THR) |=> $stable(mode_o));

   a_r8_no_ready_powered_down: assert property (@(posedge clk_i) disable iff (rst_i)
      mode_o != 2'b00 |-> !ready_o);

   a_r9_hold_in_full: assert property (@(posedge clk_i) disable iff (rst_i)
      mode_o == 2'b10 |-> !track_o);

endmodule

bind pmd_power_decoder pmd_power_decoder_chk #(
   .COMPLETE_EDGES(COMPLETE_EDGES), .ABORT_MIN_EDGES(ABORT_MIN_EDGES), .CNT_W(CNT_W)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .mode_o(mode_o), .ready_o(ready_o),
   .track_o(track_o), .cs_rise(cs_rise), .edge_count(edge_count)
);

// File: tb/pmd_power_decoder_test.sv
module pmd_power_decoder_test;

   localparam int PW = 64;
   localparam int FW = 1500;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] rst_mode = 2'b00;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b1;
   logic [1:0] mode;
   logic       ready, track;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   pmd_power_decoder #(
      .PARTIAL_WAKE_CYC(PW), .FULL_WAKE_CYC(FW)
   ) uut (
      .clk_i(clk), .rst_i(rst), .rst_mode_i(rst_mode), .cs_n_i(cs_n),
      .sclk_i(sclk), .mode_o(mode), .ready_o(ready), .track_o(track)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply_reset(input logic [1:0] m);
      @(negedge clk);
      rst = 1'b1; rst_mode = m; cs_n = 1'b1; sclk = 1'b1;
      idle(3);
      rst = 1'b0;
      idle(3);
   endtask

   task automatic frame(input int edges, input int hp);
      cs_n = 1'b0;
      idle(4);
      for (int i = 0; i < edges; i++) begin
         sclk = 1'b0; idle(hp);
         sclk = 1'b1; idle(hp);
      end
      idle(2);
      cs_n = 1'b1;
      idle(6);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic t_reset_states();
      apply_reset(2'b00);
      check("R1", "normal reset mode", mode, 0);
      check("R1", "normal reset ready", ready, 1);
      check("R1", "normal reset track", track, 1);
      apply_reset(2'b01);
      check("R1", "partial reset mode", mode, 1);
      check("R8", "partial reset ready", ready, 0);
      check("R9", "partial reset track", track, 0);
      apply_reset(2'b11);
      check("R1", "code 3 loads full", mode, 2);
   endtask

   task automatic t_escalate();
      apply_reset(2'b00);
      frame(1, 4);
      check("R5", "1 edge in normal", mode, 0);
      frame(5, 4);
      check("R3", "5 edges from normal", mode, 1);
      check("R8", "ready in partial", ready, 0);
      check("R9", "track in partial", track, 0);
      frame(2, 4);
      check("R4", "2 edges from partial", mode, 2);
      frame(9, 2);
      check("R4", "9 edges from full", mode, 2);
      frame(0, 2);
      check("R5", "0 edges in full", mode, 2);
      frame(1, 2);
      check("R5", "1 edge in full", mode, 2);
   endtask

   task automatic t_normal_frames();
      apply_reset(2'b00);
      cs_n = 1'b0;
      idle(4);
      for (int i = 0; i < 12; i++) begin
         sclk = 1'b0; idle(2);
         sclk = 1'b1; idle(2);
      end
      check("R8", "ready inside normal frame", ready, 1);
      cs_n = 1'b1;
      idle(6);
      check("R2", "12 edges keep normal", mode, 0);
      check("R8", "ready after normal frame", ready, 1);
      frame(9, 2);
      check("R3", "9 edges from normal", mode, 1);
      frame(10, 2);
      check("R2", "10 edges exact boundary", mode, 0);
   endtask

   task automatic t_wake(input logic [1:0] start, input int delay, input string req);
      int t0;
      apply_reset(start);
      cs_n = 1'b0;
      t0 = cyc;
      idle(6);
      check("R9", "track before first sclk edge", track, 0);
      for (int i = 0; i < 10; i++) begin
         sclk = 1'b0; idle(1);
         if (i == 0) begin
            idle(3);
            check("R9", "track after first sclk edge", track, (start == 2'b01) ? 1 : 0);
         end
         sclk = 1'b1; idle(1);
      end
      idle(2);
      cs_n = 1'b1;
      idle(6);
      check("R2", "wake frame mode", mode, 0);
      check("R9", "track after wake frame", track, 1);
      wait_until(t0 + delay - 2);
      check(req, "ready before delay", ready, 0);
      wait_until(t0 + delay + 6);
      check(req, "ready after delay", ready, 1);
   endtask

   initial begin
      fork
         begin
            t_reset_states();
            t_escalate();
            t_normal_frames();
            t_wake(2'b01, PW, "R6");
            t_wake(2'b10, FW, "R7");
         end
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule